// File: doc/BRIEF.md
# Microwire Serial EEPROM Command Engine

This block drives a byte-wide Microwire serial EEPROM over four wires: chip select, serial clock, a data line towards the device and a data line from it. A host places an operation code, an address, a write byte and a 2-bit size setting on its inputs and pulses a start strobe. The engine then frames the command, generates the serial clock from the system clock, shifts the command out, and for a read collects the returned byte. After any programming operation it re-selects the device and watches the returned line until the device reports ready.

The size setting picks a 7, 9 or 11-bit address field, so one engine serves every device density in that family. Four rarely used commands (enable writes, disable writes, erase everything, write everything) share opcode 00 and are told apart by the two top bits of the address field. Polling is bounded: a device that never reports ready leaves a sticky timeout flag instead of hanging the engine.

Top module: `mw_eeprom_master`

## Requirements
- R1: `size_sel` 00, 01 and 10 select 7, 9 and 11 address bits. A start with `size_sel` = 11 or with `cmd_op` = 7 is refused: `busy` stays low and `ee_cs` never rises.
- R2: Every frame is sent MSB first: one start bit of 1, then a 2-bit opcode, then every bit of the selected address field, whatever the real device size.
- R3: `cmd_op` codes are 0 read, 1 write, 2 erase, 3 erase-all, 4 write-all, 5 write-enable and 6 write-disable. Read uses opcode 10, write uses 01 and erase uses 11.
- R4: Codes 3 to 6 send opcode 00. The two top address bits are 10 for erase-all, 01 for write-all, 11 for write-enable and 00 for write-disable. All lower address bits are 0.
- R5: One command gives 3 + address-bit serial clocks. Read, write and write-all add 8 more.
- R6: Write and write-all send `cmd_wdata` MSB first right after the address. A read sends zeros in those 8 slots. It samples `ee_din` at the last 8 rising edges, MSB first, into `rd_data`, and `rd_data` holds that value until the next read.
- R7: `ee_sck` is high only while `ee_cs` is high, and `ee_dout` does not change while `ee_sck` is high. `ee_cs` rises HALF_DIV system cycles before the first rising clock edge. Each serial clock half-period lasts HALF_DIV system cycles.
- R8: After erase, erase-all, write and write-all, `ee_cs` falls for at least one half-period and then rises again without clocks. `busy` stays high until `ee_din` is seen high. Other commands select the device exactly once.
- R9: When POLL_LIMIT half-period samples all read low, `timeout` is set, `ee_cs` falls and the engine returns to idle. `timeout` stays set until the next accepted start, and a refused start does not clear it.
- R10: `busy` is high from the cycle after an accepted start until the command ends. Start pulses while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | One-cycle strobe that launches a command |
| cmd_op | input | 3 | Operation code (R3) |
| cmd_addr | input | 11 | Word address; the low bits are used according to size_sel |
| cmd_wdata | input | 8 | Byte for write and write-all |
| size_sel | input | 2 | Address width select (R1) |
| busy | output | 1 | Command in progress |
| rd_data | output | 8 | Byte returned by the last read |
| timeout | output | 1 | Sticky ready-poll timeout |
| ee_cs | output | 1 | Device chip select, active high |
| ee_sck | output | 1 | Serial clock |
| ee_dout | output | 1 | Serial data to the device |
| ee_din | input | 1 | Serial data and ready/busy from the device |

## Verification
The assertions watch the wire discipline on every cycle: the clock stays inside chip select, the data line stays steady while the clock is high, every deselect lasts at least one half-period, refused starts leave the engine idle, and the timeout flag stays sticky. Only the bench scenarios can show the content of each frame: the opcode, the placement of the extended selector, the data byte and the clock count for each size. They also show the byte read back and whether the poll ends through ready or through timeout.

// File: rtl/mw_pkg.sv
package mw_pkg;
   typedef enum logic [2:0] {
      OP_READ  = 3'd0,
      OP_WRITE = 3'd1,
      OP_ERASE = 3'd2,
      OP_ERAL  = 3'd3,
      OP_WRAL  = 3'd4,
      OP_EWEN  = 3'd5,
      OP_EWDS  = 3'd6
   } mw_op_e;

   localparam int unsigned MW_AW_MIN = 7;
   localparam int unsigned MW_AW_MAX = 11;
   localparam int unsigned MW_DW     = 8;
   localparam int unsigned MW_FW     = 3 + MW_AW_MAX + MW_DW;
   localparam int unsigned MW_CW     = $clog2(MW_FW + 1);
endpackage

// File: rtl/mw_frame.sv
module mw_frame
   import mw_pkg::*;
(
   input  logic [2:0]           op,
   input  logic [MW_AW_MAX-1:0] addr,
   input  logic [MW_DW-1:0]     wdata,
   input  logic [1:0]           size_sel,
   output logic [MW_FW-1:0]     frame,
   output logic [MW_CW-1:0]     nclk,
   output logic                 legal,
   output logic                 is_read,
   output logic                 is_prog
);
   int unsigned          abits;
   logic [1:0]           opc;
   logic [1:0]           xsel;
   logic                 ext;
   logic                 has_data;
   logic [MW_AW_MAX-1:0] afield;
   logic [MW_DW-1:0]     dfield;
   logic [MW_FW-1:0]     head, abody, dbody;

   always_comb begin
      legal    = (size_sel != 2'b11) && (op != 3'd7);
      abits    = (size_sel == 2'b11) ? MW_AW_MIN : MW_AW_MIN + 2 * int'(size_sel);
      opc      = 2'b00;
      xsel     = 2'b00;
      ext      = 1'b0;
      has_data = 1'b0;
      is_read  = 1'b0;
      is_prog  = 1'b0;
      case (op)
         OP_READ:  begin opc = 2'b10; has_data = 1'b1; is_read = 1'b1; end
         OP_WRITE: begin opc = 2'b01; has_data = 1'b1; is_prog = 1'b1; end
         OP_ERASE: begin opc = 2'b11; is_prog = 1'b1; end
         OP_ERAL:  begin ext = 1'b1; xsel = 2'b10; is_prog = 1'b1; end
         OP_WRAL:  begin ext = 1'b1; xsel = 2'b01; has_data = 1'b1; is_prog = 1'b1; end
         OP_EWEN:  begin ext = 1'b1; xsel = 2'b11; end
         default:  begin ext = 1'b1; xsel = 2'b00; end
      endcase
      if (ext)
         afield = {xsel, {(MW_AW_MAX-2){1'b0}}} >> (MW_AW_MAX - abits);
      else
         afield = addr & ({MW_AW_MAX{1'b1}} >> (MW_AW_MAX - abits));
      dfield = (has_data && !is_read) ? wdata : '0;
      head   = MW_FW'({1'b1, opc}) << (abits + MW_DW);
      abody  = MW_FW'(afield) << MW_DW;
      dbody  = MW_FW'(dfield);
      frame  = (head | abody | dbody) << (MW_AW_MAX - abits);
      nclk   = MW_CW'(3 + abits + (has_data ? MW_DW : 0));
   end
endmodule

// File: rtl/mw_tick.sv
module mw_tick #(
   parameter int unsigned HALF_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   if (HALF_DIV < 1) begin : g_bad_div
      $error("HALF_DIV must be at least 1");
   end

   if (HALF_DIV == 1) begin : g_direct
      assign tick = run;
   end else begin : g_count
      localparam int unsigned TW = $clog2(HALF_DIV);
      logic [TW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cnt <= '0;
         else if (!run || cnt == TW'(HALF_DIV - 1))
            cnt <= '0;
         else
            cnt <= cnt + 1'b1;
      end
      assign tick = run && (cnt == TW'(HALF_DIV - 1));
   end
endmodule

// File: rtl/mw_eeprom_master.sv
module mw_eeprom_master
   import mw_pkg::*;
#(
   parameter int unsigned HALF_DIV   = 4,
   parameter int unsigned POLL_LIMIT = 64
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_start,
   input  logic [2:0]  cmd_op,
   input  logic [10:0] cmd_addr,
   input  logic [7:0]  cmd_wdata,
   input  logic [1:0]  size_sel,
   output logic        busy,
   output logic [7:0]  rd_data,
   output logic        timeout,
   output logic        ee_cs,
   output logic        ee_sck,
   output logic        ee_dout,
   input  logic        ee_din
);
   localparam int unsigned PCW = $clog2(POLL_LIMIT + 1);

   if (POLL_LIMIT < 1) begin : g_bad_poll
      $error("POLL_LIMIT must be at least 1");
   end

   typedef enum logic [2:0] {ST_IDLE, ST_SHIFT, ST_GAP, ST_PCS, ST_POLL, ST_END} st_e;

   st_e              state;
   logic [MW_FW-1:0] sreg;
   logic [MW_CW-1:0] bit_cnt, nclk_q, dstart_q;
   logic             read_q, prog_q;
   logic [7:0]       rd_sh;
   logic [PCW-1:0]   poll_cnt;
   logic             tmo_q, cs_q, sk_q;
   logic             tick;

   logic [MW_FW-1:0] f_frame;
   logic [MW_CW-1:0] f_nclk;
   logic             f_legal, f_read, f_prog;

   mw_frame u_frame (
      .op(cmd_op), .addr(cmd_addr), .wdata(cmd_wdata), .size_sel(size_sel),
      .frame(f_frame), .nclk(f_nclk), .legal(f_legal),
      .is_read(f_read), .is_prog(f_prog)
   );

   mw_tick #(.HALF_DIV(HALF_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(state != ST_IDLE), .tick(tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE; sreg <= '0; bit_cnt <= '0; nclk_q <= '0; dstart_q <= '0;
         read_q <= 1'b0; prog_q <= 1'b0; rd_sh <= '0; poll_cnt <= '0;
         tmo_q <= 1'b0; cs_q <= 1'b0; sk_q <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: if (cmd_start && f_legal) begin
               state    <= ST_SHIFT;
               cs_q     <= 1'b1;
               sk_q     <= 1'b0;
               sreg     <= f_frame;
               bit_cnt  <= '0;
               nclk_q   <= f_nclk;
               dstart_q <= f_nclk - MW_CW'(MW_DW);
               read_q   <= f_read;
               prog_q   <= f_prog;
               poll_cnt <= '0;
               tmo_q    <= 1'b0;
            end
            ST_SHIFT: if (tick) begin
               if (!sk_q) begin
                  sk_q <= 1'b1;
                  if (read_q && bit_cnt >= dstart_q)
                     rd_sh <= {rd_sh[6:0], ee_din};
               end else begin
                  sk_q <= 1'b0;
                  if (bit_cnt == nclk_q - 1'b1) begin
                     state <= ST_GAP;
                     cs_q  <= 1'b0;
                     sreg  <= '0;
                  end else begin
                     bit_cnt <= bit_cnt + 1'b1;
                     sreg    <= sreg << 1;
                  end
               end
            end
            ST_GAP: if (tick) begin
               if (prog_q) begin
                  state <= ST_PCS;
                  cs_q  <= 1'b1;
               end else
                  state <= ST_IDLE;
            end
            ST_PCS: if (tick) state <= ST_POLL;
            ST_POLL: if (tick) begin
               if (ee_din) begin
                  cs_q  <= 1'b0;
                  state <= ST_END;
               end else if (poll_cnt == PCW'(POLL_LIMIT - 1)) begin
                  tmo_q <= 1'b1;
                  cs_q  <= 1'b0;
                  state <= ST_END;
               end else
                  poll_cnt <= poll_cnt + 1'b1;
            end
            default: if (tick) state <= ST_IDLE;
         endcase
      end
   end

   assign busy    = (state != ST_IDLE);
   assign rd_data = rd_sh;
   assign timeout = tmo_q;
   assign ee_cs   = cs_q;
   assign ee_sck  = sk_q;
   assign ee_dout = sreg[MW_FW-1];

   // R7: serial clock only inside a selected window
   p_sck_in_cs_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ee_sck |-> ee_cs);
   // R7: data to the device holds while the clock is high
   p_dout_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ee_sck |-> $stable(ee_dout));
   // R10: idle engine leaves the device deselected
   p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !ee_cs);
   // R1: reserved size never launches a command
   p_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cmd_start && size_sel == 2'b11) |=> !busy);
   // R8: deselect lasts beyond a single cycle
   p_cs_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (HALF_DIV > 1 && $fell(ee_cs)) |=> !ee_cs);
   // R9: timeout flag is sticky until a command is accepted
   p_tmo_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout && !(cmd_start && !busy)) |=> timeout);
endmodule

// File: tb/mw_eeprom_master_test.sv
`timescale 1ns/1ps
module mw_eeprom_master_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_start = 1'b0;
   logic [2:0]  cmd_op = '0;
   logic [10:0] cmd_addr = '0;
   logic [7:0]  cmd_wdata = '0;
   logic [1:0]  size_sel = '0;
   logic        busy, timeout, ee_cs, ee_sck, ee_dout;
   logic [7:0]  rd_data;
   logic        ee_din = 1'b1;

   int unsigned checks = 0;
   int unsigned fails = 0;
   int unsigned rises = 0;
   int unsigned cs_rises = 0;
   int unsigned poll_cyc = 0;
   int unsigned cur_ab = 7;
   int unsigned cur_rdly = 0;
   logic [7:0]  cur_rb = '0;
   logic [31:0] cap = '0;

   always #2 clk = ~clk;

   mw_eeprom_master uut (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .size_sel(size_sel),
      .busy(busy), .rd_data(rd_data), .timeout(timeout),
      .ee_cs(ee_cs), .ee_sck(ee_sck), .ee_dout(ee_dout), .ee_din(ee_din)
   );

   always @(posedge ee_sck) begin
      cap = {cap[30:0], ee_dout};
      rises = rises + 1;
   end
   always @(posedge ee_cs) cs_rises = cs_rises + 1;

   // device model: read byte during data slots, ready after a delay when polled
   always @(negedge clk) begin
      if (ee_cs && cs_rises >= 2) begin
         ee_din <= (poll_cyc >= cur_rdly);
         poll_cyc = poll_cyc + 1;
      end else if (rises >= 3 + cur_ab && rises < 11 + cur_ab)
         ee_din <= cur_rb[7 - (rises - 3 - cur_ab)];
      else
         ee_din <= 1'b1;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int unsigned act, input int unsigned exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic bit has_data(input int op);
      return op == 0 || op == 1 || op == 4;
   endfunction
   function automatic bit is_prog(input int op);
      return op >= 1 && op <= 4;
   endfunction
   function automatic int unsigned exp_len(input int op, input int size);
      return 3 + 7 + 2 * size + (has_data(op) ? 8 : 0);
   endfunction
   function automatic logic [31:0] exp_bits(input int op, input logic [10:0] a,
                                            input logic [7:0] wd, input int size);
      int unsigned ab = 7 + 2 * size;
      logic [31:0] v = 32'd1;
      logic [1:0]  opc = 2'b00;
      logic [1:0]  sel = 2'b00;
      bit          ext = 1'b1;
      case (op)
         0: begin opc = 2'b10; ext = 0; end
         1: begin opc = 2'b01; ext = 0; end
         2: begin opc = 2'b11; ext = 0; end
         3: sel = 2'b10;
         4: sel = 2'b01;
         5: sel = 2'b11;
         default: sel = 2'b00;
      endcase
      v = (v << 2) | 32'(opc);
      if (ext) v = (v << ab) | (32'(sel) << (ab - 2));
      else     v = (v << ab) | (32'(a) & ((32'd1 << ab) - 1));
      if (has_data(op)) v = (v << 8) | ((op == 0) ? 32'd0 : 32'(wd));
      return v;
   endfunction

   task automatic run_cmd(input int op, input logic [10:0] a, input logic [7:0] wd,
                          input int size, input logic [7:0] rb,
                          input int unsigned rdly, input bit exp_tmo);
      int unsigned guard = 0;
      int unsigned len = exp_len(op, size);
      logic [31:0] eb = exp_bits(op, a, wd, size);
      logic [31:0] mask = (len >= 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 1);
      @(negedge clk);
      cmd_op = 3'(op); cmd_addr = a; cmd_wdata = wd; size_sel = 2'(size);
      cap = '0; rises = 0; cs_rises = 0; poll_cyc = 0;
      cur_ab = 7 + 2 * size; cur_rb = rb; cur_rdly = rdly;
      cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
      check(busy == 1'b1, "R10", "busy after start", busy, 1);
      // R10: a second start while busy must not restart the frame
      cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
      while (busy && guard < 5000) begin
         @(negedge clk);
         guard++;
      end
      check(guard < 5000, "R10", "command completes", guard, 0);
      check(rises == len, "R5", $sformatf("clock count op%0d size%0d", op, size), rises, len);
      check((cap & mask) == eb, (op >= 3) ? "R4" : "R3",
            $sformatf("frame bits R2 op%0d size%0d", op, size), cap & mask, eb);
      check(cs_rises == (is_prog(op) ? 2 : 1), "R8", "select count", cs_rises,
            is_prog(op) ? 2 : 1);
      if (op == 0)
         check(rd_data == rb, "R6", "read byte", rd_data, rb);
      check(timeout == exp_tmo, "R9", "timeout flag", timeout, exp_tmo);
   endtask

   initial begin
      int unsigned cyc = 0;
      while (cyc < 150000) begin
         @(posedge clk);
         cyc++;
      end
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      check(busy == 0 && ee_cs == 0 && ee_sck == 0 && timeout == 0, "R10",
            "reset state", {busy, ee_cs, ee_sck, timeout}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // directed: every operation at every size
      for (int s = 0; s < 3; s++)
         for (int op = 0; op < 7; op++)
            run_cmd(op, 11'h5A5 ^ 11'(op * 37), 8'hC3 ^ 8'(s), s, 8'h96, 20, 1'b0);

      // R9: a device that never reports ready
      run_cmd(1, 11'h012, 8'h7E, 0, 8'h00, 100000, 1'b1);
      // R1: reserved size refused; R9: flag survives a refused start
      @(negedge clk);
      cs_rises = 0; size_sel = 2'b11; cmd_op = 3'd0; cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
      repeat (40) @(negedge clk);
      check(busy == 0 && cs_rises == 0, "R1", "reserved size ignored", cs_rises, 0);
      check(timeout == 1'b1, "R9", "sticky over refused start", timeout, 1);
      // R1: illegal operation code refused
      size_sel = 2'b00; cmd_op = 3'd7; cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
      repeat (40) @(negedge clk);
      check(busy == 0 && cs_rises == 0, "R1", "illegal op ignored", cs_rises, 0);
      // R9: accepted command clears the flag
      run_cmd(5, 11'h000, 8'h00, 1, 8'h00, 0, 1'b0);
      // R8: device ready at the first poll sample
      run_cmd(2, 11'h7FF, 8'h00, 2, 8'h00, 0, 1'b0);
      // R6: read boundary bytes
      run_cmd(0, 11'h7FF, 8'h00, 2, 8'h80, 0, 1'b0);
      run_cmd(0, 11'h001, 8'h00, 0, 8'h01, 0, 1'b0);

      // random mix
      for (int i = 0; i < 20; i++)
         run_cmd(int'($urandom % 7), 11'($urandom), 8'($urandom), int'($urandom % 3),
                 8'($urandom), $urandom % 120, 1'b0);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule